// File: doc/BRIEF.md
# Configurable Cache Replacement State Unit

This block holds the replacement bookkeeping for a four-way set-associative cache and names the way to evict when a lookup misses. Three policies are available and are chosen by a plain control input: least recently used (a 2-bit age per way per set), first-in first-out (a 2-bit rotating pointer per set), and random (the low bits of a free-running 16-bit LFSR). The age state of each way lives in its own storage slice, and each slice has its own enable. The enable vector is driven out, so power models can see exactly when the replacement storage is touched.

Each policy touches the replacement storage under its own rule. LRU touches all four slices on every lookup. FIFO touches them only when a lookup misses. Random never touches them. A saturating counter adds up the enabled slices on every lookup, which gives a direct count of replacement-array accesses.

Lookups arrive as a one-cycle valid strobe with a set index, a hit flag and the hit way. The unit can take one lookup in every cycle and applies no back-pressure, so it has no ready signal. The victim way is combinational from the presented set index, so the cache can use it in the same cycle as the miss. The policy input must be held steady while lookups are in flight.

Top module: `cache_repl_unit`

## Requirements
- R1: With policy code 2'b00 (LRU), every cycle with `lkp_valid` high drives `sub_en` to 4'b1111, whether the lookup hits or misses.
- R2: With policy code 2'b01 (FIFO), `sub_en` is 4'b1111 on a valid lookup with `lkp_hit` low. It is 4'b0000 on a valid lookup with `lkp_hit` high.
- R3: With policy code 2'b10 or 2'b11 (random), `sub_en` stays 4'b0000 on every lookup.
- R4: `sub_en` is 4'b0000 in every cycle where `lkp_valid` is low.
- R5: Under LRU, a hit gives the hit way age 0. Every way whose age was below the hit way's old age gains one, and the other ways keep their age. A hit on the way that already has age 0 changes nothing.
- R6: Under LRU, `victim_way` is the way of the presented set whose age is 3. A miss makes that way age 0 and adds one to the age of every other way.
- R7: Under FIFO, `victim_way` is the set's pointer. The pointer steps by one, wrapping from 3 to 0, after each miss in that set. Hits leave it unchanged.
- R8: Under random, `victim_way` is the low two bits of a 16-bit LFSR (taps 16,14,13,11) that shifts every cycle and never holds zero. The reported way therefore changes over time.
- R9: After reset, every set's LRU ages equal the way index, so the victim is way 3. Every FIFO pointer is 0 and `access_count` is 0.
- R10: `access_count` adds the number of set bits of `sub_en` on each valid lookup and is visible one cycle later. It saturates at all ones instead of wrapping.
- R11: Sets keep separate state. The state of a policy that is not selected stays frozen while another policy is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 2 | 00 LRU, 01 FIFO, 10/11 random |
| lkp_valid | input | 1 | One lookup this cycle |
| lkp_set | input | SET_W | Set index of the lookup |
| lkp_hit | input | 1 | Lookup hit in the cache |
| lkp_hit_way | input | 2 | Way that hit |
| victim_way | output | 2 | Way to replace for the presented set |
| sub_en | output | WAYS | Per-way replacement storage enables |
| access_count | output | CNT_W | Saturating count of enabled slices |

## Verification
The bench hits the same way twice in a row, so that it has age 0. An update rule that ages every way on every access would move the victim at that point. It then switches from LRU to FIFO and random and back, and expects the LRU victim to be unchanged. A design that updates ages regardless of the selected policy would fail that check. It drives FIFO misses past the pointer wrap and a FIFO hit in the middle: a pointer that also advances on hits, or that wraps wrongly, reports the wrong way. Finally, it drives the counter past its top value. A wrapping adder would return to a small value there instead of holding at all ones.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic [1:0] {
    POL_LRU  = 2'b00,
    POL_FIFO = 2'b01,
    POL_RND  = 2'b10,
    POL_RND2 = 2'b11
  } policy_e;
endpackage

// File: rtl/repl_lru_bank.sv
module repl_lru_bank #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int AW = $clog2(WAYS),
  localparam int SW = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW-1:0]   rd_set,
  input  logic [WAYS-1:0] upd_en,
  input  logic            hit,
  input  logic [AW-1:0]   hit_way,
  output logic [AW-1:0]   victim
);
  logic [WAYS-1:0][AW-1:0] cur_age;
  logic [WAYS-1:0][AW-1:0] nxt_age;
  logic [AW-1:0] use_way;

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (cur_age[w] == AW'(WAYS - 1)) victim = AW'(w);
  end

  assign use_way = hit ? hit_way : victim;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (AW'(w) == use_way)                nxt_age[w] = '0;
      else if (cur_age[w] < cur_age[use_way]) nxt_age[w] = cur_age[w] + 1'b1;
      else                                   nxt_age[w] = cur_age[w];
    end
  end

  // one storage slice per way, each with its own enable
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [AW-1:0] mem [SETS];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) mem[s] <= AW'(w);
      end else if (upd_en[w]) begin
        mem[rd_set] <= nxt_age[w];
      end
    end
    assign cur_age[w] = mem[rd_set];
  end
endmodule

// File: rtl/repl_fifo_bank.sv
module repl_fifo_bank #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int AW = $clog2(WAYS),
  localparam int SW = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] rd_set,
  input  logic          advance,
  output logic [AW-1:0] victim
);
  logic [AW-1:0] ptr_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (advance) begin
      ptr_q[rd_set] <= ptr_q[rd_set] + 1'b1;
    end
  end

  assign victim = ptr_q[rd_set];
endmodule

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk) begin
    if (!rst_n) state <= W'(SEED);
    else        state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/repl_access_counter.sv
module repl_access_counter #(
  parameter int IN_W  = 4,
  parameter int CNT_W = 32,
  localparam int PW = $clog2(IN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [IN_W-1:0]  en,
  output logic [CNT_W-1:0] count
);
  logic [PW-1:0]  ones;
  logic [CNT_W:0] sum;

  always_comb begin
    ones = '0;
    for (int i = 0; i < IN_W; i++) ones = ones + PW'(en[i]);
  end

  assign sum = {1'b0, count} + (CNT_W + 1)'(ones);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (valid)   count <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/cache_repl_unit.sv
module cache_repl_unit
  import repl_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int CNT_W = 32,
  localparam int AW = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy_sel,
  input  logic             lkp_valid,
  input  logic [SET_W-1:0] lkp_set,
  input  logic             lkp_hit,
  input  logic [AW-1:0]    lkp_hit_way,
  output logic [AW-1:0]    victim_way,
  output logic [WAYS-1:0]  sub_en,
  output logic [CNT_W-1:0] access_count
);
  policy_e pol;
  logic [AW-1:0] lru_victim, fifo_victim;
  logic [15:0]   lfsr_q;
  logic [WAYS-1:0] lru_en;
  logic fifo_adv;

  assign pol = policy_e'(policy_sel);

  always_comb begin
    sub_en = '0;
    if (lkp_valid) begin
      unique case (pol)
        POL_LRU:  sub_en = '1;
        POL_FIFO: sub_en = lkp_hit ? '0 : '1;
        default:  sub_en = '0;
      endcase
    end
  end

  assign lru_en   = (pol == POL_LRU) ? sub_en : '0;
  assign fifo_adv = (pol == POL_FIFO) && (|sub_en);

  repl_lru_bank #(.WAYS(WAYS), .SETS(SETS)) i_lru (
    .clk(clk), .rst_n(rst_n), .rd_set(lkp_set), .upd_en(lru_en),
    .hit(lkp_hit), .hit_way(lkp_hit_way), .victim(lru_victim)
  );

  repl_fifo_bank #(.WAYS(WAYS), .SETS(SETS)) i_fifo (
    .clk(clk), .rst_n(rst_n), .rd_set(lkp_set), .advance(fifo_adv),
    .victim(fifo_victim)
  );

  repl_lfsr #(.W(16)) i_lfsr (.clk(clk), .rst_n(rst_n), .state(lfsr_q));

  repl_access_counter #(.IN_W(WAYS), .CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .valid(lkp_valid), .en(sub_en),
    .count(access_count)
  );

  always_comb begin
    unique case (pol)
      POL_LRU:  victim_way = lru_victim;
      POL_FIFO: victim_way = fifo_victim;
      default:  victim_way = lfsr_q[AW-1:0];
    endcase
  end
endmodule

// File: rtl/cache_repl_unit_chk.sv
module cache_repl_unit_chk #(
  parameter int WAYS  = 4,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       policy_sel,
  input logic             lkp_valid,
  input logic             lkp_hit,
  input logic [WAYS-1:0]  sub_en,
  input logic [CNT_W-1:0] access_count,
  input logic [15:0]      lfsr_q
);
  // R1
  lru_all_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && policy_sel == 2'b00) |-> (sub_en == '1));
  // R2
  fifo_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && policy_sel == 2'b01 && lkp_hit) |-> (sub_en == '0));
  // R3
  rnd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    policy_sel[1] |-> (sub_en == '0));
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |-> (sub_en == '0));
  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lkp_valid && rst_n) |=> $stable(access_count));
  // R10
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (access_count >= $past(access_count)));
endmodule

bind cache_repl_unit cache_repl_unit_chk #(.WAYS(WAYS), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .lkp_valid(lkp_valid),
  .lkp_hit(lkp_hit), .sub_en(sub_en), .access_count(access_count),
  .lfsr_q(lfsr_q)
);

// File: tb/test_cache_repl_unit.sv
module test_cache_repl_unit;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] policy_sel = 2'b00;
  logic       lkp_valid = 0;
  logic [3:0] lkp_set = '0;
  logic       lkp_hit = 0;
  logic [1:0] lkp_hit_way = '0;
  logic [1:0] victim_way;
  logic [3:0] sub_en;
  logic [7:0] access_count;

  int checks = 0;
  int errors = 0;
  logic [1:0] s_vic;
  logic [3:0] s_en;

  always #2 clk = ~clk;

  cache_repl_unit #(.WAYS(4), .SETS(16), .CNT_W(8)) i_cache_repl_unit (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .lkp_valid(lkp_valid),
    .lkp_set(lkp_set), .lkp_hit(lkp_hit), .lkp_hit_way(lkp_hit_way),
    .victim_way(victim_way), .sub_en(sub_en), .access_count(access_count)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one lookup; captures victim and enables before the edge
  task automatic lookup(int set, bit hit, int way);
    @(negedge clk);
    lkp_valid = 1; lkp_set = 4'(set); lkp_hit = hit; lkp_hit_way = 2'(way);
    #1 s_vic = victim_way; s_en = sub_en;
    @(negedge clk);
    lkp_valid = 0; lkp_hit = 0;
  endtask

  task automatic peek(int set);
    @(negedge clk);
    lkp_valid = 0; lkp_set = 4'(set);
    #1 s_vic = victim_way; s_en = sub_en;
  endtask

  task automatic t_reset();
    peek(0);
    check("R9 victim", s_vic, 3);
    check("R4 idle en", s_en, 0);
    check("R9 count", access_count, 0);
  endtask

  task automatic t_lru();
    policy_sel = 2'b00;
    lookup(2, 1, 3); check("R1 hit en", s_en, 15);
    peek(2); check("R5 victim", s_vic, 2);
    lookup(2, 1, 0);
    peek(2); check("R5 victim2", s_vic, 2);
    lookup(2, 0, 0); check("R6 miss victim", s_vic, 2);
    check("R1 miss en", s_en, 15);
    peek(2); check("R6 after fill", s_vic, 1);
    lookup(2, 1, 2);
    peek(2); check("R5 age0 hit", s_vic, 1);
    peek(5); check("R11 other set", s_vic, 3);
    check("R4 idle en", s_en, 0);
    check("R10 count", access_count, 16);
  endtask

  task automatic t_fifo();
    int exp_v;
    policy_sel = 2'b01;
    lookup(1, 1, 2); check("R2 hit en", s_en, 0);
    check("R10 no add", access_count, 16);
    for (int i = 0; i < 5; i++) begin
      lookup(1, 0, 0);
      exp_v = i % 4;
      check("R7 victim", s_vic, exp_v);
      check("R2 miss en", s_en, 15);
      if (i == 2) begin
        lookup(1, 1, 1); check("R2 mid hit", s_en, 0);
        peek(1); check("R7 hit keep", s_vic, 3);
      end
    end
    peek(4); check("R11 fifo set", s_vic, 0);
    check("R10 fifo count", access_count, 36);
  endtask

  task automatic t_rand();
    bit [3:0] seen = '0;
    int n = 0;
    policy_sel = 2'b10;
    lookup(2, 0, 0); check("R3 miss en", s_en, 0);
    lookup(2, 1, 1); check("R3 hit en", s_en, 0);
    policy_sel = 2'b11;
    lookup(3, 0, 0); check("R3 code3 en", s_en, 0);
    policy_sel = 2'b10;
    for (int i = 0; i < 16; i++) begin
      peek(0); seen[s_vic] = 1'b1;
    end
    for (int i = 0; i < 4; i++) n += int'(seen[i]);
    checks++;
    if (n < 2) begin
      errors++;
      $display("FAIL R8: actual %0d distinct expected >=2", n);
    end
    check("R3 count", access_count, 36);
    policy_sel = 2'b00;
    peek(2); check("R11 lru frozen", s_vic, 1);
    policy_sel = 2'b01;
    peek(1); check("R11 fifo frozen", s_vic, 1);
  endtask

  task automatic t_sat();
    policy_sel = 2'b00;
    for (int i = 0; i < 54; i++) lookup(7, 1, 0);
    check("R10 near top", access_count, 252);
    lookup(7, 1, 0);
    check("R10 saturate", access_count, 255);
    lookup(7, 0, 0);
    check("R10 hold top", access_count, 255);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_lru();
    t_fifo();
    t_rand();
    t_sat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule